// File: doc/BRIEF.md
# Fetch Aligner with Decoupling Instruction Queue

This block sits at the front of a multi-issue pipeline. Every cycle it takes one aligned instruction-cache block, along with the fetch PC that falls inside that block. It picks out the instructions from the PC's slot onward and writes them, each with its own PC, into a circular queue that feeds decode. The group of instructions is cut short by the end of the block. It is also cut short by a predicted-taken branch, which is given as a slot index and a target. The block then returns the PC to fetch on the next cycle.

Fetch groups vary in size. The queue holds the extra instructions from long groups, so decode keeps getting work on cycles when fetch brings in only one or two. Decode takes up to W instructions per cycle from the head of the queue. When the queue cannot accept a whole group, the block asserts backpressure and keeps the same PC. A misprediction flush empties the queue and sends fetch to the corrected PC.

Top module: `fa_fetch_aligner`

## Requirements
- R1: After reset the queue is empty: `dq_count` is 0 and every bit of `dq_valid` is low.
- R2: Each instruction is 4 bytes and a block holds W of them, so the slot of the fetch PC is `fetch_pc[log2(W)+1:2]`. A valid block with no taken branch enqueues every slot from that slot to slot W-1. A PC in the last slot enqueues exactly one instruction.
- R3: If `br_taken` is set and `br_slot` is at or after the start slot, the group ends at `br_slot` and includes that slot. Later slots are dropped, and `next_pc` equals `br_target`.
- R4: If no taken branch applies and the group is enqueued, `next_pc` is the base address of the next sequential block, which is the aligned block base plus 4*W.
- R5: A `br_slot` that lies before the start slot is ignored. The group runs to the end of the block and `next_pc` is sequential.
- R6: A group is enqueued only if the free entries before this cycle's pop (DEPTH minus `dq_count`) cover the whole group. If they do not, `fetch_stall` is high, `next_pc` equals `fetch_pc`, and nothing is written.
- R7: When `blk_valid` is low and there is no flush, nothing is enqueued, `fetch_stall` is low and `next_pc` equals `fetch_pc`.
- R8: Lane i of the decode outputs holds the i-th oldest entry. `dq_valid[i]` is high exactly when i < `dq_count`. Each entry carries its instruction word and its PC. A cycle with `deq` high removes min(W, `dq_count`) entries in program order.
- R9: `flush` overrides a push and a pop in the same cycle. The queue is empty on the next cycle, `next_pc` equals `flush_pc`, and `fetch_stall` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | PC_W | PC of the current fetch |
| blk_valid | input | 1 | Cache block data is valid this cycle |
| blk_data | input | W*ILEN | Aligned cache block, slot 0 in the low bits |
| br_taken | input | 1 | A branch in this block is predicted taken |
| br_slot | input | log2(W) | Slot of the predicted-taken branch |
| br_target | input | PC_W | Predicted target address |
| flush | input | 1 | Misprediction flush |
| flush_pc | input | PC_W | Corrected restart PC |
| deq | input | 1 | Decode takes min(W, count) entries |
| next_pc | output | PC_W | PC for the next fetch |
| fetch_stall | output | 1 | Group rejected because the queue lacks room |
| dq_count | output | log2(DEPTH+1) | Current queue occupancy |
| dq_valid | output | W | Valid mask of the decode lanes |
| dq_insn | output | W*ILEN | Instruction words for the decode lanes |
| dq_pc | output | W*PC_W | PCs for the decode lanes |

## Verification
The bench builds the block with W=4 and DEPTH=6. With a queue this shallow, a single four-instruction group followed by one more group is enough to hit the room check, so the stall boundary comes up within a few cycles. The bench sweeps every start slot against every taken-branch slot, both with and without a taken prediction. Those runs cover truncation at the block end, truncation at the branch, and branches that come before the start slot. Further sequences fill the queue, drain it partially so that fewer than W entries remain, and send a flush in the same cycle as a push and a pop.

// File: rtl/fa_pkg.sv
package fa_pkg;
  // Add an offset to a ring index and wrap it once at depth.
  function automatic int unsigned fa_wrap(input int unsigned a, input int unsigned b,
                                          input int unsigned depth);
    int unsigned s;
    s = a + b;
    return (s >= depth) ? s - depth : s;
  endfunction
endpackage

// File: rtl/fa_extract.sv
module fa_extract #(
  parameter int W    = 4,
  parameter int ILEN = 32,
  parameter int PC_W = 32
) (
  input  logic [PC_W-1:0]      fetch_pc,
  input  logic                 blk_valid,
  input  logic [W*ILEN-1:0]    blk_data,
  input  logic                 br_taken,
  input  logic [$clog2(W)-1:0] br_slot,
  input  logic [PC_W-1:0]      br_target,
  output logic [$clog2(W):0]   grp_cnt,
  output logic [PC_W-1:0]      grp_next_pc,
  output logic [W*ILEN-1:0]    lane_insn,
  output logic [W*PC_W-1:0]    lane_pc
);
  localparam int SLOT_W    = $clog2(W);
  localparam int OFF_W     = SLOT_W + 2;
  localparam int BLK_BYTES = 4 * W;

  logic [SLOT_W-1:0] start_slot;
  logic [PC_W-1:0]   blk_base;
  logic              taken_ok;
  logic [SLOT_W:0]   last_slot;

  always_comb begin
    start_slot  = fetch_pc[OFF_W-1:2];
    blk_base    = {fetch_pc[PC_W-1:OFF_W], {OFF_W{1'b0}}};
    taken_ok    = br_taken && (br_slot >= start_slot);
    last_slot   = taken_ok ? {1'b0, br_slot} : (SLOT_W+1)'(W - 1);
    grp_cnt     = blk_valid ? (last_slot - {1'b0, start_slot} + 1'b1) : '0;
    grp_next_pc = taken_ok ? br_target : blk_base + PC_W'(BLK_BYTES);
  end

  // Shift the block so that the start slot lands in lane 0.
  for (genvar i = 0; i < W; i++) begin : g_lane
    logic [SLOT_W:0] src;
    always_comb begin
      src = {1'b0, start_slot} + (SLOT_W+1)'(i);
      lane_insn[i*ILEN +: ILEN] = (src < (SLOT_W+1)'(W)) ?
                                  blk_data[src[SLOT_W-1:0]*ILEN +: ILEN] : '0;
      lane_pc[i*PC_W +: PC_W]   = blk_base + PC_W'({src, 2'b00});
    end
  end
endmodule

// File: rtl/fa_queue.sv
module fa_queue
  import fa_pkg::*;
#(
  parameter int W     = 4,
  parameter int DEPTH = 18,
  parameter int ILEN  = 32,
  parameter int PC_W  = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic [$clog2(W):0]           push_n,
  input  logic [W*ILEN-1:0]            push_insn,
  input  logic [W*PC_W-1:0]            push_pc,
  input  logic                         pop_req,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic [W-1:0]                 out_valid,
  output logic [W*ILEN-1:0]            out_insn,
  output logic [W*PC_W-1:0]            out_pc
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [ILEN-1:0]  mem_insn [DEPTH];
  logic [PC_W-1:0]  mem_pc   [DEPTH];
  logic [IDX_W-1:0] head_q, head_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, pop_n;
  logic [IDX_W-1:0] tail;

  always_comb begin
    pop_n = '0;
    if (pop_req) pop_n = (cnt_q < CNT_W'(W)) ? cnt_q : CNT_W'(W);
    tail = IDX_W'(fa_wrap(32'(head_q), 32'(cnt_q), DEPTH));
    if (flush) begin
      head_d = '0;
      cnt_d  = '0;
    end else begin
      head_d = IDX_W'(fa_wrap(32'(head_q), 32'(pop_n), DEPTH));
      cnt_d  = cnt_q - pop_n + CNT_W'(push_n);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= head_d;
      cnt_q  <= cnt_d;
    end
  end

  // Storage holds no reset value; writes are enabled per lane.
  always_ff @(posedge clk) begin
    for (int i = 0; i < W; i++) begin
      if (!flush && (i < int'(push_n))) begin
        mem_insn[fa_wrap(32'(tail), i, DEPTH)] <= push_insn[i*ILEN +: ILEN];
        mem_pc[fa_wrap(32'(tail), i, DEPTH)]   <= push_pc[i*PC_W +: PC_W];
      end
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_out
    always_comb begin
      out_valid[i]             = (CNT_W'(i) < cnt_q);
      out_insn[i*ILEN +: ILEN] = mem_insn[fa_wrap(32'(head_q), i, DEPTH)];
      out_pc[i*PC_W +: PC_W]   = mem_pc[fa_wrap(32'(head_q), i, DEPTH)];
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/fa_fetch_aligner.sv
module fa_fetch_aligner #(
  parameter int W     = 4,
  parameter int DEPTH = 18,
  parameter int ILEN  = 32,
  parameter int PC_W  = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [PC_W-1:0]            fetch_pc,
  input  logic                       blk_valid,
  input  logic [W*ILEN-1:0]          blk_data,
  input  logic                       br_taken,
  input  logic [$clog2(W)-1:0]       br_slot,
  input  logic [PC_W-1:0]            br_target,
  input  logic                       flush,
  input  logic [PC_W-1:0]            flush_pc,
  input  logic                       deq,
  output logic [PC_W-1:0]            next_pc,
  output logic                       fetch_stall,
  output logic [$clog2(DEPTH+1)-1:0] dq_count,
  output logic [W-1:0]               dq_valid,
  output logic [W*ILEN-1:0]          dq_insn,
  output logic [W*PC_W-1:0]          dq_pc
);
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam int GRP_W = $clog2(W) + 1;

  logic [GRP_W-1:0]  grp_cnt;
  logic [PC_W-1:0]   grp_next_pc;
  logic [W*ILEN-1:0] lane_insn;
  logic [W*PC_W-1:0] lane_pc;
  logic              room;
  logic [GRP_W-1:0]  push_n;

  fa_extract #(.W(W), .ILEN(ILEN), .PC_W(PC_W)) u_extract (
    .fetch_pc(fetch_pc), .blk_valid(blk_valid), .blk_data(blk_data),
    .br_taken(br_taken), .br_slot(br_slot), .br_target(br_target),
    .grp_cnt(grp_cnt), .grp_next_pc(grp_next_pc),
    .lane_insn(lane_insn), .lane_pc(lane_pc)
  );

  always_comb begin
    room        = (32'(DEPTH) - 32'(dq_count)) >= 32'(grp_cnt);
    fetch_stall = blk_valid && !flush && !room;
    push_n      = (blk_valid && !flush && room) ? grp_cnt : '0;
    if (flush)                    next_pc = flush_pc;
    else if (!blk_valid || !room) next_pc = fetch_pc;
    else                          next_pc = grp_next_pc;
  end

  fa_queue #(.W(W), .DEPTH(DEPTH), .ILEN(ILEN), .PC_W(PC_W)) u_queue (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push_n(push_n), .push_insn(lane_insn), .push_pc(lane_pc),
    .pop_req(deq), .count(dq_count),
    .out_valid(dq_valid), .out_insn(dq_insn), .out_pc(dq_pc)
  );

  logic [CNT_W-1:0] unused_cnt_w;
  assign unused_cnt_w = '0;
endmodule

// File: rtl/fa_checker.sv
module fa_checker #(
  parameter int W     = 4,
  parameter int DEPTH = 18,
  parameter int PC_W  = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [PC_W-1:0]            fetch_pc,
  input logic                       blk_valid,
  input logic                       flush,
  input logic [PC_W-1:0]            flush_pc,
  input logic [PC_W-1:0]            next_pc,
  input logic                       fetch_stall,
  input logic [$clog2(DEPTH+1)-1:0] dq_count,
  input logic [W-1:0]               dq_valid
);
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    32'(dq_count) <= DEPTH);

  assert_stall_holds_pc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stall |-> next_pc == fetch_pc);

  assert_stall_no_growth_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stall |=> dq_count <= $past(dq_count));

  assert_idle_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!blk_valid && !flush) |-> (next_pc == fetch_pc && !fetch_stall));

  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> dq_count == 0);

  assert_flush_redirect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (next_pc == flush_pc && !fetch_stall));

  assert_lane_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((dq_valid & (dq_valid + 1'b1)) == '0) &&
    (32'($countones(dq_valid)) == ((32'(dq_count) < W) ? 32'(dq_count) : W)));
endmodule

bind fa_fetch_aligner fa_checker #(.W(W), .DEPTH(DEPTH), .PC_W(PC_W)) u_fa_checker (
  .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .blk_valid(blk_valid),
  .flush(flush), .flush_pc(flush_pc), .next_pc(next_pc),
  .fetch_stall(fetch_stall), .dq_count(dq_count), .dq_valid(dq_valid)
);

// File: tb/tb_fa_fetch_aligner.sv
module tb_fa_fetch_aligner;
  localparam int W = 4, DEPTH = 6, ILEN = 32, PC_W = 32;
  localparam logic [31:0] KEY = 32'hC0DE_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [PC_W-1:0] fetch_pc = '0, br_target = '0, flush_pc = '0;
  logic blk_valid = 1'b0, br_taken = 1'b0, flush = 1'b0, deq = 1'b0;
  logic [W*ILEN-1:0] blk_data = '0;
  logic [1:0] br_slot = '0;
  logic [PC_W-1:0] next_pc;
  logic fetch_stall;
  logic [2:0] dq_count;
  logic [W-1:0] dq_valid;
  logic [W*ILEN-1:0] dq_insn;
  logic [W*PC_W-1:0] dq_pc;

  int n_tests = 0, n_fail = 0;
  logic [31:0] mq [0:63];
  int mocc = 0;

  always #2 clk = ~clk;

  fa_fetch_aligner #(.W(W), .DEPTH(DEPTH), .ILEN(ILEN), .PC_W(PC_W)) dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_q(input string req);
    logic [W-1:0] m;
    m = '0;
    for (int i = 0; i < W; i++) if (i < mocc) m[i] = 1'b1;
    chk(dq_count == 3'(mocc), req, "count", 32'(dq_count), 32'(mocc));
    chk(dq_valid == m, "R8", "valid mask", 32'(dq_valid), 32'(m));
    for (int i = 0; i < W; i++) if (i < mocc) begin
      chk(dq_pc[i*PC_W +: PC_W] == mq[i], "R8", "lane pc",
          dq_pc[i*PC_W +: PC_W], mq[i]);
      chk(dq_insn[i*ILEN +: ILEN] == (mq[i] ^ KEY), req, "lane insn",
          dq_insn[i*ILEN +: ILEN], mq[i] ^ KEY);
    end
  endtask

  // Called at a negedge; ends at a negedge after checking the queue.
  task automatic step(input logic [31:0] pc, input bit v, input bit tk, input int slot,
                      input logic [31:0] tgt, input bit dq, input bit fl,
                      input logic [31:0] fpc, input string req);
    int st, last, cnt, np;
    bit tok, room;
    logic [31:0] base, exp_pc;
    bit exp_stall;
    base = {pc[31:4], 4'b0};
    st = int'(pc[3:2]);
    tok = tk && (slot >= st);
    last = tok ? slot : W - 1;
    cnt = v ? last - st + 1 : 0;
    room = (DEPTH - mocc) >= cnt;
    exp_stall = v && !fl && !room;
    exp_pc = fl ? fpc : (!v || !room) ? pc : tok ? tgt : base + 32'd16;
    fetch_pc = pc; blk_valid = v; br_taken = tk; br_slot = 2'(slot);
    br_target = tgt; deq = dq; flush = fl; flush_pc = fpc;
    for (int k = 0; k < W; k++) blk_data[k*ILEN +: ILEN] = (base + 32'(4*k)) ^ KEY;
    #1;
    chk(next_pc == exp_pc, req, "next_pc", next_pc, exp_pc);
    chk(fetch_stall == exp_stall, req, "stall", 32'(fetch_stall), 32'(exp_stall));
    @(posedge clk);
    if (fl) mocc = 0;
    else begin
      np = dq ? ((mocc < W) ? mocc : W) : 0;
      for (int i = 0; i + np < mocc; i++) mq[i] = mq[i+np];
      mocc -= np;
      if (v && room) for (int i = 0; i < cnt; i++) mq[mocc++] = base + 32'(4*(st+i));
    end
    #1;
    blk_valid = 1'b0; deq = 1'b0; flush = 1'b0;
    @(negedge clk);
    check_q(req);
  endtask

  initial begin
    #(200000*4);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_q("R1");
    chk(dq_valid == '0, "R1", "valid after reset", 32'(dq_valid), 0);
    // R7: invalid block leaves PC and queue alone
    step(32'h0000_0208, 1'b0, 1'b1, 3, 32'h900, 1'b0, 1'b0, 0, "R7");
    // R2/R3/R4/R5 sweep: every start slot, taken or not, every branch slot
    for (int st = 0; st < W; st++)
      for (int tk = 0; tk < 2; tk++)
        for (int sl = 0; sl < W; sl++) begin
          string rq;
          rq = (tk == 0) ? "R2" : (sl < st) ? "R5" : "R3";
          step(32'h1000 + 32'(64*sl) + 32'(4*st), 1'b1, tk[0], sl,
               32'h4000 + 32'(16*st), 1'b0, 1'b0, 0, rq);
          step(0, 1'b0, 1'b0, 0, 0, 1'b1, 1'b0, 0, "R8");
          step(0, 1'b0, 1'b0, 0, 0, 1'b1, 1'b0, 0, "R4");
        end
    // R6: fill a 6-entry queue
    step(32'h2000, 1'b1, 1'b0, 0, 0, 1'b0, 1'b0, 0, "R4");
    step(32'h2010, 1'b1, 1'b0, 0, 0, 1'b0, 1'b0, 0, "R6");
    step(32'h2018, 1'b1, 1'b0, 0, 0, 1'b0, 1'b0, 0, "R6");
    step(32'h202C, 1'b1, 1'b0, 0, 0, 1'b0, 1'b0, 0, "R6");
    // R6: room measured before the same-cycle pop
    step(32'h2030, 1'b1, 1'b0, 0, 0, 1'b1, 1'b0, 0, "R6");
    // R8: partial drain with fewer than W left
    step(0, 1'b0, 1'b0, 0, 0, 1'b1, 1'b0, 0, "R8");
    step(0, 1'b0, 1'b0, 0, 0, 1'b1, 1'b0, 0, "R8");
    // R9: flush with push and pop in the same cycle
    step(32'h3000, 1'b1, 1'b0, 0, 0, 1'b0, 1'b0, 0, "R2");
    step(32'h3010, 1'b1, 1'b1, 1, 32'h5000, 1'b1, 1'b1, 32'h7770, "R9");
    step(32'h7770, 1'b1, 1'b0, 0, 0, 1'b0, 1'b0, 0, "R2");
    step(32'h7780, 1'b1, 1'b0, 0, 0, 1'b0, 1'b1, 32'h8880, "R9");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule